// File: doc/BRIEF.md
# Paged DMA Physical Address Builder

This block turns the 16-bit running address of a DMA channel into a 24-bit physical address. It places an 8-bit page value above the counter. Each of the eight channels has its own page register. Software loads a page register through a small write port. Counting never changes a page, so a transfer that runs past the top or bottom of its counter range wraps around inside the same 64 KiB block. It does not move on to the next block.

Every lookup carries a width flag. For a byte lookup, the counter supplies address bits 15:0 unchanged. For a word lookup, the counter is shifted left by one. The counter's most-significant bit is discarded, so word transfers touch only even addresses and still stay inside one 64 KiB block. The intended use is two cascaded four-channel groups: channels 0–3 carry bytes and channels 4–7 carry words. The block computes the address from the flag it is given. A one-cycle wrap pulse marks each lookup that crossed the counter's boundary relative to the previous lookup.

Top module: `dma_page_addr_gen`

## Requirements
- R1: For a byte lookup (width flag 0), the output address is page × 65536 + counter, i.e. bits 23:16 = page register of the channel and bits 15:0 = counter.
- R2: For a word lookup (width flag 1), bits 23:16 = page, bits 15:1 = counter bits 14:0 and bit 0 = 0; counter bit 15 has no effect on the address.
- R3: Each channel selects its own page register; a write to one channel's page leaves the addresses of every other channel unchanged.
- R4: A page register changes only on a write to it, so an ascending run of 256 byte lookups from counter 0xFF8C on page 0x03 produces 0x3FF8C..0x3FFFF then 0x30000..0x3008B.
- R5: After reset all page registers are 0 and addr_vld_o, addr_o and wrap_o are 0.
- R6: addr_vld_o, addr_o and wrap_o appear exactly one clock after the lookup is presented with cnt_vld_i = 1; with cnt_vld_i = 0 addr_vld_o is 0 the next cycle.
- R7: wrap_o is 1 for a lookup on the same channel as the previous valid lookup when the counted span moved from all-ones to zero or from zero to all-ones; the span is 16 bits for byte lookups and the low 15 bits for word lookups.
- R8: wrap_o stays 0 when the previous valid lookup was on another channel, and for any step that does not cross the span boundary.
- R9: A page write and a lookup of the same channel in the same cycle use the old page; the new page applies from the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pg_we_i | input | 1 | Page register write strobe |
| pg_sel_i | input | 3 | Channel whose page is written |
| pg_data_i | input | 8 | Page value to write |
| cnt_vld_i | input | 1 | Lookup request valid |
| cnt_ch_i | input | 3 | Channel of the lookup |
| cnt_i | input | 16 | Current counter value |
| wide_i | input | 1 | 1 = word lookup, 0 = byte lookup |
| addr_vld_o | output | 1 | Output address valid |
| addr_o | output | 24 | Physical address |
| wrap_o | output | 1 | Counter span boundary crossed on this lookup |

## Verification
On every cycle, the assertions check these properties: a page register holds its value whenever no write is made; word addresses are even; the valid output trails the request by exactly one cycle; and a wrap pulse appears only together with a valid address. The bench scenarios cover the rest. One scenario steps through the 256-byte ascending run and shows the block wrap back to the start of the page. Another scenario sweeps every channel, both widths and single-bit and boundary counter values, to show the exact address composition. Further scenarios show the wrap pulse on both widths, its absence when the channel changes, and the old-page behaviour when a write and a lookup meet in the same cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    parameter int unsigned DPA_CHANNELS = 8;
    parameter int unsigned DPA_CNT_W    = 16;
    parameter int unsigned DPA_PAGE_W   = 8;

    typedef enum logic {
        WIDTH_BYTE = 1'b0,
        WIDTH_WORD = 1'b1
    } xfer_width_e;

endpackage

// File: rtl/dpa_page_file.sv
module dpa_page_file #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned PAGE_W = 8,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [CH_W-1:0]   wsel_i,
    input  logic [PAGE_W-1:0] wdata_i,
    input  logic [CH_W-1:0]   rsel_i,
    output logic [PAGE_W-1:0] rdata_o
);

    logic [NUM_CH-1:0][PAGE_W-1:0] page_d, page_q;

    always_comb begin
        page_d = page_q;
        if (we_i) begin
            page_d[wsel_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            page_q <= '0;
        end else begin
            page_q <= page_d;
        end
    end

    assign rdata_o = page_q[rsel_i];

    AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(page_q)); // R4

endmodule

// File: rtl/dpa_addr_form.sv
module dpa_addr_form
    import dpa_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PAGE_W = 8,
    localparam int unsigned ADDR_W = CNT_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  xfer_width_e       width_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        unique case (width_i)
            WIDTH_WORD: addr_o = {page_i, cnt_i[CNT_W-2:0], 1'b0};
            default:    addr_o = {page_i, cnt_i};
        endcase
    end

endmodule

// File: rtl/dpa_wrap_det.sv
module dpa_wrap_det
    import dpa_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vld_i,
    input  logic [CH_W-1:0]  ch_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  xfer_width_e      width_i,
    output logic             wrap_o
);

    typedef struct packed {
        logic             seen;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] cnt;
    } hist_t;

    hist_t hist_d, hist_q;

    logic [CNT_W-1:0] span_max;
    logic [CNT_W-1:0] cur_lo, prev_lo;
    logic             same_ch;

    always_comb begin
        span_max = (width_i == WIDTH_WORD) ? {1'b0, {(CNT_W-1){1'b1}}}
                                           : {CNT_W{1'b1}};
        cur_lo   = cnt_i & span_max;
        prev_lo  = hist_q.cnt & span_max;
        same_ch  = hist_q.seen && (hist_q.ch == ch_i);
        wrap_o   = vld_i && same_ch &&
                   (((prev_lo == span_max) && (cur_lo == '0)) ||
                    ((prev_lo == '0) && (cur_lo == span_max)));
        hist_d   = hist_q;
        if (vld_i) begin
            hist_d.seen = 1'b1;
            hist_d.ch   = ch_i;
            hist_d.cnt  = cnt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dpa_pkg::*;
#(
    parameter int unsigned NUM_CH = DPA_CHANNELS,
    parameter int unsigned CNT_W  = DPA_CNT_W,
    parameter int unsigned PAGE_W = DPA_PAGE_W,
    localparam int unsigned CH_W   = $clog2(NUM_CH),
    localparam int unsigned ADDR_W = CNT_W + PAGE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pg_we_i,
    input  logic [CH_W-1:0]   pg_sel_i,
    input  logic [PAGE_W-1:0] pg_data_i,
    input  logic              cnt_vld_i,
    input  logic [CH_W-1:0]   cnt_ch_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wide_i,
    output logic              addr_vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              wrap;
    } out_t;

    out_t out_d, out_q;

    xfer_width_e       width;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] addr_next;
    logic              wrap_next;

    assign width = wide_i ? WIDTH_WORD : WIDTH_BYTE;

    dpa_page_file #(
        .NUM_CH (NUM_CH),
        .PAGE_W (PAGE_W)
    ) page_file_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (pg_we_i),
        .wsel_i  (pg_sel_i),
        .wdata_i (pg_data_i),
        .rsel_i  (cnt_ch_i),
        .rdata_o (page)
    );

    dpa_addr_form #(
        .CNT_W  (CNT_W),
        .PAGE_W (PAGE_W)
    ) addr_form_i (
        .page_i  (page),
        .cnt_i   (cnt_i),
        .width_i (width),
        .addr_o  (addr_next)
    );

    dpa_wrap_det #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) wrap_det_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vld_i   (cnt_vld_i),
        .ch_i    (cnt_ch_i),
        .cnt_i   (cnt_i),
        .width_i (width),
        .wrap_o  (wrap_next)
    );

    always_comb begin
        out_d      = out_q;
        out_d.vld  = cnt_vld_i;
        out_d.wrap = wrap_next;
        if (cnt_vld_i) begin
            out_d.addr = addr_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_vld_o = out_q.vld;
    assign addr_o     = out_q.addr;
    assign wrap_o     = out_q.wrap;

    AST_WORD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_vld_o && $past(wide_i)) |-> (addr_o[0] == 1'b0)); // R2

    AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_vld_i |=> addr_vld_o); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_vld_i |=> !addr_vld_o); // R6

    AST_WRAP_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> addr_vld_o); // R7

endmodule

// File: tb/dma_page_addr_gen_tb_top.sv
module dma_page_addr_gen_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        pg_we_i = 1'b0;
    logic [2:0]  pg_sel_i = '0;
    logic [7:0]  pg_data_i = '0;
    logic        cnt_vld_i = 1'b0;
    logic [2:0]  cnt_ch_i = '0;
    logic [15:0] cnt_i = '0;
    logic        wide_i = 1'b0;
    logic        addr_vld_o;
    logic [23:0] addr_o;
    logic        wrap_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int page_m [8];
    bit prev_seen = 0;
    int prev_ch = 0;
    int prev_cnt = 0;

    always #2.5 clk_i = ~clk_i;

    dma_page_addr_gen dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pg_we_i    (pg_we_i),
        .pg_sel_i   (pg_sel_i),
        .pg_data_i  (pg_data_i),
        .cnt_vld_i  (cnt_vld_i),
        .cnt_ch_i   (cnt_ch_i),
        .cnt_i      (cnt_i),
        .wide_i     (wide_i),
        .addr_vld_o (addr_vld_o),
        .addr_o     (addr_o),
        .wrap_o     (wrap_o)
    );

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(int pg, int cnt, bit wide);
        if (wide) return pg * 65536 + (cnt % 32768) * 2;
        return pg * 65536 + cnt;
    endfunction

    task automatic write_page(int ch, int val);
        @(negedge clk_i);
        cnt_vld_i = 1'b0;
        pg_we_i   = 1'b1;
        pg_sel_i  = ch[2:0];
        pg_data_i = val[7:0];
        @(posedge clk_i);
        page_m[ch] = val;
        @(negedge clk_i);
        pg_we_i = 1'b0;
    endtask

    task automatic lookup(string req, int ch, int cnt, bit wide, bit also_write, int wval);
        int m;
        int a;
        int b;
        int ea;
        bit ew;
        @(negedge clk_i);
        cnt_vld_i = 1'b1;
        cnt_ch_i  = ch[2:0];
        cnt_i     = cnt[15:0];
        wide_i    = wide;
        pg_we_i   = also_write;
        pg_sel_i  = ch[2:0];
        pg_data_i = wval[7:0];
        ea = exp_addr(page_m[ch], cnt, wide);
        m  = wide ? 32768 : 65536;
        a  = prev_cnt % m;
        b  = cnt % m;
        ew = prev_seen && (prev_ch == ch) &&
             (((a == m - 1) && (b == 0)) || ((a == 0) && (b == m - 1)));
        prev_seen = 1;
        prev_ch   = ch;
        prev_cnt  = cnt;
        @(posedge clk_i);
        if (also_write) page_m[ch] = wval;
        #1;
        pg_we_i = 1'b0;
        check_val({req, " vld"}, int'(addr_vld_o), 1);
        check_val({req, " addr"}, int'(addr_o), ea);
        check_val({req, " wrap"}, int'(wrap_o), int'(ew));
    endtask

    task automatic idle_check();
        @(negedge clk_i);
        cnt_vld_i = 1'b0;
        @(posedge clk_i);
        #1;
        check_val("R6 idle vld", int'(addr_vld_o), 0);
        check_val("R8 idle wrap", int'(wrap_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) page_m[i] = 0;
        repeat (3) @(posedge clk_i);
        #1;
        check_val("R5 reset vld", int'(addr_vld_o), 0);
        check_val("R5 reset addr", int'(addr_o), 0);
        check_val("R5 reset wrap", int'(wrap_o), 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        idle_check();

        // R5: pages start at zero on every channel
        for (int ch = 0; ch < 8; ch++) lookup("R5 zero page", ch, 16'h1234 + ch, 1'b0, 1'b0, 0);

        // R3: distinct page per channel
        for (int ch = 0; ch < 8; ch++) write_page(ch, 8'h11 * ch + 8'h05);

        // R1/R2 sweep over channels, widths, bit positions and boundaries
        for (int ch = 0; ch < 8; ch++) begin
            for (int w = 0; w < 2; w++) begin
                lookup(w ? "R2 word" : "R1 byte", ch, 16'h0000, w[0], 1'b0, 0);
                lookup(w ? "R2 word" : "R1 byte", ch, 16'hFFFF, w[0], 1'b0, 0);
                lookup(w ? "R2 word" : "R1 byte", ch, 16'h8000, w[0], 1'b0, 0);
                lookup(w ? "R2 word" : "R1 byte", ch, 16'h7FFF, w[0], 1'b0, 0);
                for (int b = 0; b < 16; b++) begin
                    lookup(w ? "R2 word" : "R1 byte", ch, 1 << b, w[0], 1'b0, 0);
                end
            end
        end

        // R2: counter bit 15 has no effect on a word address
        lookup("R2 msb ignored", 5, 16'h8123, 1'b1, 1'b0, 0);
        lookup("R2 msb ignored", 5, 16'h0123, 1'b1, 1'b0, 0);

        // R3: rewrite one page, others unchanged
        write_page(2, 8'hA7);
        for (int ch = 0; ch < 8; ch++) lookup("R3 isolate", ch, 16'h4321, ch >= 4, 1'b0, 0);

        // R4: 256-byte ascending run wraps inside its 64 KiB block
        write_page(1, 8'h03);
        lookup("R8 other ch", 0, 16'h5555, 1'b0, 1'b0, 0);
        for (int i = 0; i < 256; i++) begin
            lookup("R4 run", 1, (16'hFF8C + i) & 16'hFFFF, 1'b0, 1'b0, 0);
            if (i == 8'h73) check_val("R4 last of block", int'(addr_o), 24'h03FFFF);
            if (i == 8'h74) begin
                check_val("R4 wrap to base", int'(addr_o), 24'h030000);
                check_val("R7 byte wrap up", int'(wrap_o), 1);
            end
            if (i == 255) check_val("R4 run end", int'(addr_o), 24'h03008B);
        end

        // R7: descending byte wrap and word wraps on 15-bit span
        lookup("R7 byte down", 3, 16'h0000, 1'b0, 1'b0, 0);
        lookup("R7 byte down", 3, 16'hFFFF, 1'b0, 1'b0, 0);
        check_val("R7 byte down pulse", int'(wrap_o), 1);
        lookup("R7 word down", 6, 16'h0000, 1'b1, 1'b0, 0);
        lookup("R7 word down", 6, 16'hFFFF, 1'b1, 1'b0, 0);
        check_val("R7 word down pulse", int'(wrap_o), 1);
        lookup("R7 word up", 6, 16'h7FFF, 1'b1, 1'b0, 0);
        lookup("R7 word up", 6, 16'h8000, 1'b1, 1'b0, 0);
        check_val("R7 word up pulse", int'(wrap_o), 1);

        // R8: no wrap across channels, nor on a plain step
        lookup("R8 cross ch", 0, 16'hFFFF, 1'b0, 1'b0, 0);
        lookup("R8 cross ch", 1, 16'h0000, 1'b0, 1'b0, 0);
        check_val("R8 cross ch no pulse", int'(wrap_o), 0);
        lookup("R8 plain step", 1, 16'h0001, 1'b0, 1'b0, 0);
        check_val("R8 plain step no pulse", int'(wrap_o), 0);
        idle_check();

        // R9: same-cycle write and lookup uses the old page
        lookup("R9 old page", 7, 16'h0ABC, 1'b1, 1'b1, 8'h5C);
        check_val("R9 old page value", int'(addr_o[23:16]), 8'h11 * 7 + 8'h05);
        lookup("R9 new page", 7, 16'h0ABC, 1'b1, 1'b0, 0);
        check_val("R9 new page value", int'(addr_o[23:16]), 8'h5C);

        idle_check();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule